// File: doc/BRIEF.md
# Remote On/Off Debounce Sequencer

This block turns the raw, asynchronous remote on/off request of a switching power supply into a clean on request and a converter shutdown command. The request input is active low: low asks for power, high asks for power to be removed. The input passes through a two-stage synchronizer. After that, a change in either direction has to stay stable for a programmable debounce interval before the block acts on it. Any bounce shorter than that interval restarts the count and leaves the outputs as they were.

Turn-off is staggered. Once the off request is debounced, the block drops its on request, and the power-good logic uses that to pull power-good low. The block then waits for the power-good logic to report that power-good has fallen. From that report it keeps the converter running for a fixed hold interval, and only then raises shutdown. Power-good therefore warns the load before the rails collapse. Once started, the off sequence always runs to completion.

Top module: `remote_onoff_seq`

## Requirements
- R1: During and right after synchronous reset (rst_n low at a clock edge), shutdown_o is 1 and on_req_o is 0.
- R2: From the off state, if onoff_n_i goes low and stays low, on_req_o rises and shutdown_o falls together. This happens exactly DBNC_CYC+3 clock edges after the first edge that samples the low level: two synchronizer edges, one decision edge and DBNC_CYC counting edges.
- R3: From the off state, a low pulse on onoff_n_i lasting fewer than DBNC_CYC clock periods leaves on_req_o at 0 and shutdown_o at 1.
- R4: From the on state, if onoff_n_i goes high and stays high, on_req_o falls exactly DBNC_CYC+2 clock edges after the first edge that samples the high level, while shutdown_o stays 0.
- R5: From the on state, a high pulse on onoff_n_i lasting fewer than DBNC_CYC clock periods leaves on_req_o at 1 and shutdown_o at 0.
- R6: After on_req_o has fallen, shutdown_o stays 0 until pg_fell_i is sampled high. It then rises at the HOLD_CYC-th clock edge after the edge that first samples pg_fell_i high.
- R7: Changes on onoff_n_i between the fall of on_req_o and the rise of shutdown_o are ignored: the off sequence completes. A later low request then needs a full fresh debounce.
- R8: pg_fell_i has no effect outside the phase that waits for power-good to fall. While the block is on, pulsing pg_fell_i keeps on_req_o at 1 and shutdown_o at 0, and a later turn-off still waits for a new pg_fell_i.
- R9: on_req_o and shutdown_o are never 1 at the same time, and shutdown_o never rises in the cycle straight after on_req_o was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| onoff_n_i | input | 1 | Raw asynchronous remote request; 0 = power on, 1 = power off |
| pg_fell_i | input | 1 | From the power-good logic: high once power-good has gone low |
| on_req_o | output | 1 | Debounced on request to the power-good and fault logic |
| shutdown_o | output | 1 | Converter shutdown command; 1 = converter stopped |

## Verification
The assertions make two assumptions. Reset is synchronous and is held across at least one edge at start-up. pg_fell_i is a level or a pulse that is only meaningful while the block waits for power-good to drop. The stimulus drives onoff_n_i and pg_fell_i only on falling clock edges, and takes its glitch lengths, hold times and power-good response delays from a seeded $urandom. Glitch lengths are kept strictly below the debounce interval, so every pulse is meant either to be ignored or to be held long enough to act. pg_fell_i is also pulsed deliberately while the block is on and while it waits, to show that it is ignored there and acted on only in the wait phase.

// File: rtl/ros_pkg.sv
// Package: shared types of the remote on/off sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ros_pkg;

    // Sequencer phases, stored in a binary-encoded register.
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,  // converter stopped, waiting for a low request
        ST_ON_PEND = 3'd1,  // low request seen, debounce running
        ST_ON      = 3'd2,  // converter running, on request asserted
        ST_PG_DROP = 3'd3,  // on request withdrawn, waiting for power-good to fall
        ST_OFF_DLY = 3'd4   // power-good low, hold time before shutdown
    } seq_state_t;

endpackage

// File: rtl/ros_sync.sv
// Module: ros_sync
// Brings an asynchronous level into the clock domain through a chain of
// STAGES flip-flops. Assumes the input changes slowly compared to the clock.
module ros_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: sample the raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                // Later stages: shift the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ros_span_ctr.sv
// Module: ros_span_ctr
// Counts consecutive cycles while run_i is high. done_o is high in the cycle
// that completes LIMIT consecutive run cycles. Dropping run_i clears the count.
// Assumes LIMIT >= 2.
module ros_span_ctr #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Terminal detect: the LIMIT-th consecutive run cycle.
    assign done_o = run_i && (cnt_q == LAST);

    // Count run cycles; restart on an idle cycle or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (done_o)      cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    // R3 R5 R6: the count never passes the terminal value.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3 R5: an idle cycle always restarts the interval.
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !done_o || (LIMIT == 1));

endmodule

// File: rtl/ros_fsm.sv
// Module: ros_fsm
// Phase controller: debounces the synchronized request with the debounce
// counter, withdraws the on request, waits for power-good to fall, then holds
// the converter for the hold counter before raising shutdown.
// Assumes: off_req_i is synchronous (1 = off requested).
module ros_fsm
    import ros_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic off_req_i,
    input  logic pg_fell_i,
    input  logic dbnc_done_i,
    input  logic hold_done_i,
    output logic dbnc_run_o,
    output logic hold_run_o,
    output logic on_req_o,
    output logic shutdown_o
);

    seq_state_t state_q, state_d;
    logic       on_q, sd_q;

    // Debounce runs while the request disagrees with the settled state.
    assign dbnc_run_o = ((state_q == ST_ON_PEND) && !off_req_i) ||
                        ((state_q == ST_ON)      &&  off_req_i);
    // Hold interval runs for the whole off-delay phase.
    assign hold_run_o = (state_q == ST_OFF_DLY);

    // Next-phase decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (!off_req_i)       state_d = ST_ON_PEND;
            ST_ON_PEND: if (off_req_i)        state_d = ST_OFF;
                        else if (dbnc_done_i) state_d = ST_ON;
            ST_ON:      if (dbnc_done_i)      state_d = ST_PG_DROP;
            ST_PG_DROP: if (pg_fell_i)        state_d = ST_OFF_DLY;
            ST_OFF_DLY: if (hold_done_i)      state_d = ST_OFF;
            default:                          state_d = ST_OFF;
        endcase
    end

    // Phase register and registered outputs decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            on_q    <= 1'b0;
            sd_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            on_q    <= (state_d == ST_ON);
            sd_q    <= (state_d == ST_OFF) || (state_d == ST_ON_PEND);
        end
    end

    assign on_req_o   = on_q;
    assign shutdown_o = sd_q;

    // R2: the on request only rises out of a completed debounce.
    a_r2_on_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_req_o) |-> $past(state_q) == ST_ON_PEND);

    // R6 R7: the wait for power-good leaves only on pg_fell_i.
    a_r7_drop_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PG_DROP && !pg_fell_i) |=> state_q == ST_PG_DROP);

    // R7: the hold phase can only finish into the off state.
    a_r7_hold_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF_DLY) |=> (state_q == ST_OFF_DLY || state_q == ST_OFF));

    // R8: while on and no debounced off, pg_fell_i does not move the phase.
    a_r8_pg_ignored_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON && !dbnc_done_i) |=> state_q == ST_ON);

endmodule

// File: rtl/remote_onoff_seq.sv
// Module: remote_onoff_seq (top)
// Remote on/off sequencer: synchronizer, debounce interval counter, hold
// interval counter and phase controller.
// Assumes: rst_n is synchronous and active low; onoff_n_i may be asynchronous.
module remote_onoff_seq #(
    parameter int DBNC_CYC    = 380,
    parameter int HOLD_CYC    = 28,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic onoff_n_i,
    input  logic pg_fell_i,
    output logic on_req_o,
    output logic shutdown_o
);

    logic off_req_s;
    logic dbnc_run, dbnc_done;
    logic hold_run, hold_done;

    ros_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (onoff_n_i),
        .sync_o  (off_req_s)
    );

    ros_span_ctr #(.LIMIT(DBNC_CYC)) u_dbnc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (dbnc_run),
        .done_o (dbnc_done)
    );

    ros_span_ctr #(.LIMIT(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (hold_run),
        .done_o (hold_done)
    );

    ros_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .off_req_i   (off_req_s),
        .pg_fell_i   (pg_fell_i),
        .dbnc_done_i (dbnc_done),
        .hold_done_i (hold_done),
        .dbnc_run_o  (dbnc_run),
        .hold_run_o  (hold_run),
        .on_req_o    (on_req_o),
        .shutdown_o  (shutdown_o)
    );

    // R9: never asking for power and stopping the converter at once.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(on_req_o && shutdown_o));

    // R9 R4: shutdown only rises after the on request was already gone.
    a_r9_staggered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_o) |-> !$past(on_req_o));

    // R2: turning on needs the synchronized request to be low.
    a_r2_on_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_req_o) |-> !$past(off_req_s));

endmodule

// File: tb/remote_onoff_seq_tb_top.sv
// Bench for remote_onoff_seq: seeded random glitches and delays plus
// directed edge cases; expected timing comes from bench functions.
module remote_onoff_seq_tb_top;

    localparam int N = 24;   // debounce interval
    localparam int H = 6;    // hold interval

    logic clk = 1'b0;
    logic rst_n;
    logic onoff_n;
    logic pg_fell;
    logic on_req, shutdown;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    remote_onoff_seq #(.DBNC_CYC(N), .HOLD_CYC(H), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .onoff_n_i  (onoff_n),
        .pg_fell_i  (pg_fell),
        .on_req_o   (on_req),
        .shutdown_o (shutdown)
    );

    // Edges from the first sampling edge to the output change (R2, R4).
    function automatic int on_latency();  return N + 3; endfunction
    function automatic int off_latency(); return N + 2; endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp_on, input logic exp_sd);
        vectors++;
        if (on_req !== exp_on || shutdown !== exp_sd) begin
            misses++;
            $display("FAIL %s: on_req=%b shutdown=%b expected on_req=%b shutdown=%b",
                     req, on_req, shutdown, exp_on, exp_sd);
        end
    endtask

    // R9: sampled every cycle after reset.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            vectors++;
            if (on_req === 1'b1 && shutdown === 1'b1) begin
                misses++;
                $display("FAIL R9: on_req=%b shutdown=%b expected not both 1", on_req, shutdown);
            end
        end
    end

    // Off to on with full debounce (R2).
    task automatic turn_on();
        onoff_n = 1'b0;
        step(on_latency() - 1);
        chk("R2 before end of debounce", 1'b0, 1'b1);
        step(1);
        chk("R2 on after debounce", 1'b1, 1'b0);
    endtask

    // On to off, with a power-good delay of pg_wait cycles (R4, R6).
    task automatic turn_off(input int pg_wait, input bit poke_req);
        onoff_n = 1'b1;
        step(off_latency() - 1);
        chk("R4 before end of debounce", 1'b1, 1'b0);
        step(1);
        chk("R4 on request dropped", 1'b0, 1'b0);
        if (poke_req) begin
            onoff_n = 1'b0;            // R7: request flips during the drop phase
            step(N + 2);
            onoff_n = 1'b1;
        end
        step(pg_wait);
        chk("R6 waits for power-good fall", 1'b0, 1'b0);
        pg_fell = 1'b1;
        step(1);
        pg_fell = 1'b0;
        if (poke_req) begin
            onoff_n = 1'b0;            // R7: short flip during the hold phase
            step(1);
            onoff_n = 1'b1;
            step(H - 2);
        end else begin
            step(H - 1);
        end
        chk("R6 hold before shutdown", 1'b0, 1'b0);
        step(1);
        chk("R6 shutdown after hold", 1'b0, 1'b1);
    endtask

    initial begin
        int seed;
        seed    = 7;
        void'($urandom(seed));
        rst_n   = 1'b0;
        onoff_n = 1'b0;                // request low during reset: still off
        pg_fell = 1'b0;
        step(3);
        chk("R1 reset state", 1'b0, 1'b1);
        onoff_n = 1'b1;
        step(2);
        rst_n = 1'b1;
        step(4);
        chk("R1 after reset", 1'b0, 1'b1);

        // R3: short low glitches from off.
        for (int i = 0; i < 8; i++) begin
            int len;
            len = (i == 0) ? N - 1 : $urandom_range(1, N - 1);
            onoff_n = 1'b0;
            step(len);
            onoff_n = 1'b1;
            step(N + 5);
            chk("R3 low glitch ignored", 1'b0, 1'b1);
        end

        turn_on();

        // R5: short high glitches from on.
        for (int i = 0; i < 8; i++) begin
            int len;
            len = (i == 0) ? N - 1 : $urandom_range(1, N - 1);
            onoff_n = 1'b1;
            step(len);
            onoff_n = 1'b0;
            step(N + 5);
            chk("R5 high glitch ignored", 1'b1, 1'b0);
        end

        // R8: pg_fell_i pulses while on have no effect.
        pg_fell = 1'b1;
        step(3);
        pg_fell = 1'b0;
        step(2);
        chk("R8 pg_fell ignored while on", 1'b1, 1'b0);

        // R7 directed: request flips during drop and hold phases.
        turn_off(5, 1'b1);
        step(N + 6);
        chk("R7 stays off after sequence", 1'b0, 1'b1);

        // Random full cycles (R2 R4 R6 R8).
        for (int i = 0; i < 6; i++) begin
            int dwell;
            turn_on();
            dwell = $urandom_range(1, 3 * N);
            step(dwell);
            chk("R2 on held", 1'b1, 1'b0);
            turn_off($urandom_range(0, 40), 1'b0);
            step($urandom_range(1, N));
            chk("R6 remains off", 1'b0, 1'b1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule